// File: doc/BRIEF.md
# Frame Address Slot Comparator

This block watches the receive byte stream of an Ethernet port and compares a short window of each frame against a set of programmable slots. Each byte arrives as a beat carrying its byte index within the frame and its data. A start-of-frame strobe marks the first beat and an end-of-frame strobe marks the last. A global window (a start byte offset and a length) selects which bytes are captured. Every slot holds a 48-bit value, a 48-bit ignore mask and a compare kind: off, equal, greater-than or less-than.

When a frame ends, the block produces one match bit per slot. Bit n belongs to slot n, and a downstream receive-flag word places the vector at bits 23:16. The vector stays valid until the next frame starts. Software sets up the slots, the window and the compare kinds through a plain 32-bit write port and reads them back through a combinational read port. New settings take effect at the next start of frame, so a frame in flight always sees one consistent configuration.

Top module: `frame_slot_matcher`

## Requirements
- R1: Slot n owns addresses 16n to 16n+15. The value bytes 0..3 sit at +0x0 (byte 0 in bits 7:0, byte 3 in bits 31:24). Value bytes 4 and 5 sit at +0x4 in bits 7:0 and 15:8. The ignore mask uses the same layout at +0x8 and +0xC. Reads return the stored bits, with zeros in the unused upper half of the +0x4 and +0xC words.
- R2: The window register at address 16*NUM_SLOTS holds the start byte offset in bits 14:0 and the length in bytes in bits 19:16. All other bits read as zero.
- R3: The kind register at address 16*NUM_SLOTS+4 holds a 2-bit field for slot n at bits 2n+1:2n. The encodings are 0 off, 1 equal, 2 greater-than and 3 less-than. All configuration resets to zero.
- R4: Captured window byte k is compared with value byte k. An ignore bit of 1 removes that bit from the compare on both sides, and an all-zero mask compares every bit.
- R5: An equal slot matches when the masked captured bytes equal the masked value bytes.
- R6: Greater-than and less-than compare the masked bytes as unsigned numbers, with the first captured byte as the most significant.
- R7: A slot of kind off never sets its match bit, even when its value and mask would otherwise match.
- R8: If the frame ends before every byte of the window has been seen, the whole vector is zero for that frame.
- R9: The bytes at indices start through start+len-1 are captured. A length above 6 acts as 6. A length of 0 gives an empty window: equal slots then match, and greater-than and less-than slots do not.
- R10: Configuration writes reach the compare only at the next start of frame. A write made during a frame does not change that frame's result.
- R11: In the cycle after the end-of-frame beat, match_valid is 1 and match_vec holds the result. Both hold until the edge after the next start-of-frame beat, which clears them to zero, unless that same beat also ends the frame. Both are zero after reset.
- R12: Beats and end-of-frame strobes that arrive outside a frame, before any start of frame, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Byte address for a configuration write or read |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr, combinational |
| rx_sof | input | 1 | First beat of a frame |
| rx_eof | input | 1 | Last beat of a frame |
| rx_valid | input | 1 | Beat carries a byte |
| rx_idx | input | 15 | Byte index of the beat within the frame |
| rx_data | input | 8 | Byte value |
| match_valid | output | 1 | The match vector holds a finished result |
| match_vec | output | 8 | One match bit per slot |

## Verification
The bench uses the default of eight slots. With eight slots the kind register fills all 16 of its low bits, and the window and kind registers fall at addresses 0x80 and 0x84. The slots mix all four compare kinds, so one frame exercises equal, both orderings, a masked byte and a disabled slot at once. A value whose first byte alone decides the order shows whether the byte significance is right. Further runs move the window to offset six, set lengths of 0, 2 and 9, end frames early, and rewrite a slot in mid-frame.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    localparam int KEY_BYTES   = 6;
    localparam int KEY_W       = 8 * KEY_BYTES;
    localparam int START_W     = 15;
    localparam int LEN_W       = 4;
    localparam int SPAN_W      = 3;
    localparam int DATA_W      = 32;
    localparam int SLOT_STRIDE = 16;
    localparam int VAL_LO      = 0;
    localparam int VAL_HI      = 4;
    localparam int IGN_LO      = 8;
    localparam int IGN_HI      = 12;

    typedef enum logic [1:0] {
        CMP_OFF = 2'd0,
        CMP_EQ  = 2'd1,
        CMP_GT  = 2'd2,
        CMP_LT  = 2'd3
    } cmp_kind_e;

    typedef struct packed {
        logic [KEY_W-1:0] value;
        logic [KEY_W-1:0] ignore;
    } slot_pattern_t;

    typedef struct packed {
        logic [START_W-1:0] start;
        logic [LEN_W-1:0]   len;
    } window_t;

    // Byte k of a register-order word moves to the k-th most significant byte.
    function automatic logic [KEY_W-1:0] msb_first(input logic [KEY_W-1:0] le);
        logic [KEY_W-1:0] r;
        r = '0;
        for (int k = 0; k < KEY_BYTES; k++)
            r[KEY_W-8-8*k +: 8] = le[8*k +: 8];
        return r;
    endfunction

    function automatic logic [SPAN_W-1:0] clamp_len(input logic [LEN_W-1:0] len);
        if (len > LEN_W'(KEY_BYTES))
            return SPAN_W'(KEY_BYTES);
        return len[SPAN_W-1:0];
    endfunction

    // Keeps the leading span bytes of a most-significant-first key.
    function automatic logic [KEY_W-1:0] head_mask(input logic [SPAN_W-1:0] span);
        logic [KEY_W-1:0] r;
        r = '0;
        for (int k = 0; k < KEY_BYTES; k++)
            if (k < int'(span))
                r[KEY_W-8-8*k +: 8] = 8'hFF;
        return r;
    endfunction

    function automatic logic [KEY_BYTES-1:0] need_bits(input logic [SPAN_W-1:0] span);
        logic [KEY_BYTES-1:0] r;
        r = '0;
        for (int k = 0; k < KEY_BYTES; k++)
            if (k < int'(span))
                r[k] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/fsc_cfg_regs.sv
module fsc_cfg_regs
    import fsc_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int AW        = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [AW-1:0]         addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    input  logic                  sof,
    output slot_pattern_t         eff_pat  [NUM_SLOTS],
    output cmp_kind_e             eff_kind [NUM_SLOTS],
    output window_t               eff_win,
    output cmp_kind_e             act_kind [NUM_SLOTS]
);

    localparam int WIN_ADDR  = NUM_SLOTS * SLOT_STRIDE;
    localparam int KIND_ADDR = WIN_ADDR + 4;

    slot_pattern_t stg_pat  [NUM_SLOTS];
    slot_pattern_t act_pat  [NUM_SLOTS];
    cmp_kind_e     stg_kind [NUM_SLOTS];
    window_t       stg_win;
    window_t       act_win;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < NUM_SLOTS; n++) begin
                stg_pat[n]  <= '0;
                act_pat[n]  <= '0;
                stg_kind[n] <= CMP_OFF;
                act_kind[n] <= CMP_OFF;
            end
            stg_win <= '0;
            act_win <= '0;
        end else begin
            if (sof) begin
                for (int n = 0; n < NUM_SLOTS; n++) begin
                    act_pat[n]  <= stg_pat[n];
                    act_kind[n] <= stg_kind[n];
                end
                act_win <= stg_win;
            end
            if (we) begin
                for (int n = 0; n < NUM_SLOTS; n++) begin
                    if (addr == AW'(n*SLOT_STRIDE + VAL_LO))
                        stg_pat[n].value[31:0] <= wdata;
                    if (addr == AW'(n*SLOT_STRIDE + VAL_HI))
                        stg_pat[n].value[KEY_W-1:32] <= wdata[KEY_W-33:0];
                    if (addr == AW'(n*SLOT_STRIDE + IGN_LO))
                        stg_pat[n].ignore[31:0] <= wdata;
                    if (addr == AW'(n*SLOT_STRIDE + IGN_HI))
                        stg_pat[n].ignore[KEY_W-1:32] <= wdata[KEY_W-33:0];
                    if (addr == AW'(KIND_ADDR))
                        stg_kind[n] <= cmp_kind_e'(wdata[2*n +: 2]);
                end
                if (addr == AW'(WIN_ADDR)) begin
                    stg_win.start <= wdata[START_W-1:0];
                    stg_win.len   <= wdata[16 +: LEN_W];
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int n = 0; n < NUM_SLOTS; n++) begin
            if (addr == AW'(n*SLOT_STRIDE + VAL_LO))
                rdata = stg_pat[n].value[31:0];
            if (addr == AW'(n*SLOT_STRIDE + VAL_HI))
                rdata = DATA_W'(stg_pat[n].value[KEY_W-1:32]);
            if (addr == AW'(n*SLOT_STRIDE + IGN_LO))
                rdata = stg_pat[n].ignore[31:0];
            if (addr == AW'(n*SLOT_STRIDE + IGN_HI))
                rdata = DATA_W'(stg_pat[n].ignore[KEY_W-1:32]);
        end
        if (addr == AW'(WIN_ADDR))
            rdata = DATA_W'({stg_win.len, 1'b0, stg_win.start});
        if (addr == AW'(KIND_ADDR))
            for (int n = 0; n < NUM_SLOTS; n++)
                rdata[2*n +: 2] = stg_kind[n];
    end

    // The start-of-frame beat already uses the settings it is about to latch.
    always_comb begin
        for (int n = 0; n < NUM_SLOTS; n++) begin
            eff_pat[n]  = sof ? stg_pat[n]  : act_pat[n];
            eff_kind[n] = sof ? stg_kind[n] : act_kind[n];
        end
        eff_win = sof ? stg_win : act_win;
    end

endmodule

// File: rtl/fsc_window_capture.sv
module fsc_window_capture
    import fsc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sof,
    input  logic               eof,
    input  logic               valid,
    input  logic [START_W-1:0] idx,
    input  logic [7:0]         data,
    input  window_t            win,
    output logic [KEY_W-1:0]   key_le,
    output logic [SPAN_W-1:0]  span,
    output logic               full,
    output logic               frame_end,
    output logic               frame_open
);

    logic [KEY_BYTES-1:0] got;
    logic [KEY_BYTES-1:0] got_n;
    logic [KEY_W-1:0]     cap;
    logic [START_W:0]     rel;
    logic                 live;
    logic                 in_win;

    always_comb begin
        span   = clamp_len(win.len);
        live   = valid && (sof || frame_open);
        rel    = {1'b0, idx} - {1'b0, win.start};
        in_win = live && (idx >= win.start) && (rel < (START_W+1)'(span));
        got_n  = sof ? '0 : got;
        key_le = sof ? '0 : cap;
        for (int k = 0; k < KEY_BYTES; k++) begin
            if (in_win && rel == (START_W+1)'(k)) begin
                got_n[k]          = 1'b1;
                key_le[8*k +: 8]  = data;
            end
        end
        full      = (got_n & need_bits(span)) == need_bits(span);
        frame_end = eof && (sof || frame_open);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_open <= 1'b0;
            got        <= '0;
            cap        <= '0;
        end else begin
            if (frame_end)
                frame_open <= 1'b0;
            else if (sof)
                frame_open <= 1'b1;
            got <= got_n;
            cap <= key_le;
        end
    end

endmodule

// File: rtl/fsc_slot_unit.sv
module fsc_slot_unit
    import fsc_pkg::*;
(
    input  logic [KEY_W-1:0]  key_msb,
    input  logic [SPAN_W-1:0] span,
    input  slot_pattern_t     pat,
    input  cmp_kind_e         kind,
    output logic              hit
);

    logic [KEY_W-1:0] keep;
    logic [KEY_W-1:0] lhs;
    logic [KEY_W-1:0] rhs;

    always_comb begin
        keep = head_mask(span) & ~msb_first(pat.ignore);
        lhs  = key_msb & keep;
        rhs  = msb_first(pat.value) & keep;
        unique case (kind)
            CMP_EQ:  hit = (lhs == rhs);
            CMP_GT:  hit = (lhs > rhs);
            CMP_LT:  hit = (lhs < rhs);
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/frame_slot_matcher.sv
module frame_slot_matcher
    import fsc_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    localparam int AW = $clog2(NUM_SLOTS * SLOT_STRIDE + 8)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [AW-1:0]        cfg_addr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    output logic [DATA_W-1:0]    cfg_rdata,
    input  logic                 rx_sof,
    input  logic                 rx_eof,
    input  logic                 rx_valid,
    input  logic [START_W-1:0]   rx_idx,
    input  logic [7:0]           rx_data,
    output logic                 match_valid,
    output logic [NUM_SLOTS-1:0] match_vec
);

    slot_pattern_t        eff_pat  [NUM_SLOTS];
    cmp_kind_e            eff_kind [NUM_SLOTS];
    cmp_kind_e            act_kind [NUM_SLOTS];
    window_t              eff_win;
    logic [KEY_W-1:0]     key_le;
    logic [KEY_W-1:0]     key_msb;
    logic [SPAN_W-1:0]    span;
    logic                 full;
    logic                 frame_end;
    logic                 frame_open;
    logic [NUM_SLOTS-1:0] hits;

    fsc_cfg_regs #(.NUM_SLOTS(NUM_SLOTS), .AW(AW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .sof      (rx_sof),
        .eff_pat  (eff_pat),
        .eff_kind (eff_kind),
        .eff_win  (eff_win),
        .act_kind (act_kind)
    );

    fsc_window_capture u_cap (
        .clk        (clk),
        .rst        (rst),
        .sof        (rx_sof),
        .eof        (rx_eof),
        .valid      (rx_valid),
        .idx        (rx_idx),
        .data       (rx_data),
        .win        (eff_win),
        .key_le     (key_le),
        .span       (span),
        .full       (full),
        .frame_end  (frame_end),
        .frame_open (frame_open)
    );

    assign key_msb = msb_first(key_le);

    for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_slot
        fsc_slot_unit u_unit (
            .key_msb (key_msb),
            .span    (span),
            .pat     (eff_pat[n]),
            .kind    (eff_kind[n]),
            .hit     (hits[n])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            match_valid <= 1'b0;
            match_vec   <= '0;
        end else if (frame_end) begin
            match_valid <= 1'b1;
            match_vec   <= full ? hits : '0;
        end else if (rx_sof) begin
            match_valid <= 1'b0;
            match_vec   <= '0;
        end
    end

endmodule

// File: rtl/fsc_checker.sv
module fsc_checker
    import fsc_pkg::*;
#(
    parameter int NUM_SLOTS = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 rx_sof,
    input logic                 rx_eof,
    input logic                 frame_open,
    input logic                 match_valid,
    input logic [NUM_SLOTS-1:0] match_vec,
    input cmp_kind_e            act_kind [NUM_SLOTS]
);

    assert_vec_qualified_R11: assert property (@(posedge clk) disable iff (rst)
        !match_valid |-> match_vec == '0)
        else $error("match_vec nonzero while match_valid is low");

    assert_clear_on_sof_R11: assert property (@(posedge clk) disable iff (rst)
        rx_sof && !rx_eof |=> !match_valid)
        else $error("result not cleared by start of frame");

    assert_result_after_eof_R11: assert property (@(posedge clk) disable iff (rst)
        rx_eof && (rx_sof || frame_open) |=> match_valid)
        else $error("no result after end of frame");

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        match_valid && !rx_sof |=> match_valid && $stable(match_vec))
        else $error("result changed before next frame");

    assert_stray_ignored_R12: assert property (@(posedge clk) disable iff (rst)
        !frame_open && !rx_sof && !match_valid |=> !match_valid)
        else $error("stray strobe produced a result");

    for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_off
        assert_disabled_silent_R7: assert property (@(posedge clk) disable iff (rst)
            match_vec[n] |-> act_kind[n] != CMP_OFF)
            else $error("disabled slot %0d matched", n);
    end

endmodule

bind frame_slot_matcher fsc_checker #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_sof      (rx_sof),
    .rx_eof      (rx_eof),
    .frame_open  (frame_open),
    .match_valid (match_valid),
    .match_vec   (match_vec),
    .act_kind    (act_kind)
);

// File: tb/frame_slot_matcher_tb.sv
module frame_slot_matcher_tb;

    localparam int NS   = 8;
    localparam int WIN  = 128;
    localparam int KIND = 132;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        rx_sof = 1'b0, rx_eof = 1'b0, rx_valid = 1'b0;
    logic [14:0] rx_idx = '0;
    logic [7:0]  rx_data = '0;
    logic        match_valid;
    logic [7:0]  match_vec;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    string cur_req = "R11";

    always #10 clk = ~clk;

    frame_slot_matcher #(.NUM_SLOTS(NS)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_valid(rx_valid), .rx_idx(rx_idx),
        .rx_data(rx_data), .match_valid(match_valid), .match_vec(match_vec)
    );

    // Reference model state
    logic [47:0] s_val[NS], s_msk[NS], a_val[NS], a_msk[NS];
    int          s_kind[NS], a_kind[NS];
    int          s_start = 0, s_len = 0, a_start = 0, a_len = 0;
    bit          m_in = 0;
    bit          got[6];
    logic [7:0]  cap[6];
    bit          exp_valid = 0;
    logic [7:0]  exp_vec = '0;
    logic [7:0]  fr[16];

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic model_step(bit sof, bit eof, bit vld, int idx, logic [7:0] d,
                              bit we, int addr, logic [31:0] wd);
        bit was_in = m_in;
        int span;
        if (sof) begin
            for (int n = 0; n < NS; n++) begin
                a_val[n] = s_val[n]; a_msk[n] = s_msk[n]; a_kind[n] = s_kind[n];
            end
            a_start = s_start; a_len = s_len; m_in = 1;
            for (int k = 0; k < 6; k++) begin got[k] = 0; cap[k] = 0; end
        end
        span = (a_len > 6) ? 6 : a_len;
        if (vld && (sof || was_in) && idx >= a_start && idx - a_start < span) begin
            cap[idx - a_start] = d;
            got[idx - a_start] = 1;
        end
        if (eof && (sof || was_in)) begin
            bit full = 1;
            logic [7:0] v = '0;
            for (int k = 0; k < span; k++) if (!got[k]) full = 0;
            for (int n = 0; n < NS; n++) begin
                logic [47:0] ka = '0, kb = '0;
                bit hit;
                for (int k = 0; k < span; k++) begin
                    logic [7:0] mk = a_msk[n][8*k +: 8];
                    ka = (ka << 8) | {40'd0, cap[k] & ~mk};
                    kb = (kb << 8) | {40'd0, a_val[n][8*k +: 8] & ~mk};
                end
                case (a_kind[n])
                    1: hit = (ka == kb);
                    2: hit = (ka > kb);
                    3: hit = (ka < kb);
                    default: hit = 0;
                endcase
                v[n] = full && hit;
            end
            exp_valid = 1; exp_vec = v; m_in = 0;
        end else if (sof) begin
            exp_valid = 0; exp_vec = '0;
        end
        if (we) begin
            if (addr < 16*NS) begin
                int n = addr / 16;
                case (addr % 16)
                    0:  s_val[n][31:0]  = wd;
                    4:  s_val[n][47:32] = wd[15:0];
                    8:  s_msk[n][31:0]  = wd;
                    12: s_msk[n][47:32] = wd[15:0];
                    default: ;
                endcase
            end else if (addr == WIN) begin
                s_start = int'(wd[14:0]); s_len = int'(wd[19:16]);
            end else if (addr == KIND) begin
                for (int n = 0; n < NS; n++) s_kind[n] = int'(wd[2*n +: 2]);
            end
        end
    endtask

    task automatic cyc(bit sof, bit eof, bit vld, int idx, logic [7:0] d,
                       bit we = 0, int addr = 0, logic [31:0] wd = 0);
        rx_sof = sof; rx_eof = eof; rx_valid = vld; rx_idx = idx[14:0]; rx_data = d;
        cfg_we = we; cfg_addr = addr[7:0]; cfg_wdata = wd;
        @(posedge clk);
        model_step(sof, eof, vld, idx, d, we, addr, wd);
        @(negedge clk);
        chk(match_valid == exp_valid && match_vec == exp_vec, cur_req, "per-cycle result",
            {23'd0, match_valid, match_vec}, {23'd0, exp_valid, exp_vec});
        rx_sof = 0; rx_eof = 0; rx_valid = 0; cfg_we = 0;
    endtask

    task automatic wr(int addr, logic [31:0] wd);
        cyc(0, 0, 0, 0, 8'h00, 1, addr, wd);
    endtask

    task automatic rd(int addr, logic [31:0] expv, string req);
        cfg_addr = addr[7:0];
        #1;
        chk(cfg_rdata == expv, req, "register read", cfg_rdata, expv);
    endtask

    task automatic prog_slot(int n, logic [47:0] val, logic [47:0] msk);
        wr(16*n + 0, val[31:0]);
        wr(16*n + 4, {16'd0, val[47:32]});
        wr(16*n + 8, msk[31:0]);
        wr(16*n + 12, {16'd0, msk[47:32]});
    endtask

    // bytes given in wire order, packed with byte 0 in the low bits
    function automatic logic [47:0] le48(logic [7:0] b0, b1, b2, b3, b4, b5);
        return {b5, b4, b3, b2, b1, b0};
    endfunction

    task automatic set_frame(logic [7:0] b0, b1, b2, b3, b4, b5);
        for (int i = 0; i < 16; i++) fr[i] = 8'hA0 + 8'(i);
        fr[0] = b0; fr[1] = b1; fr[2] = b2; fr[3] = b3; fr[4] = b4; fr[5] = b5;
    endtask

    task automatic run_frame(int n, int wr_at = -1, int wa = 0, logic [31:0] wv = 0);
        for (int i = 0; i < n; i++)
            cyc(i == 0, i == n - 1, 1, i, fr[i], i == wr_at, wa, wv);
    endtask

    task automatic expect_vec(logic [7:0] e, string req, string what);
        chk(match_valid && match_vec == e, req, what, {23'd0, match_valid, match_vec}, {23'd0, 1'b1, e});
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        for (int n = 0; n < NS; n++) begin
            s_val[n] = '0; s_msk[n] = '0; a_val[n] = '0; a_msk[n] = '0;
            s_kind[n] = 0; a_kind[n] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        chk(!match_valid && match_vec == 0, "R11", "reset outputs", {23'd0, match_valid, match_vec}, 0);
        rd(KIND, 32'h0, "R3");
        rd(WIN, 32'h0, "R2");

        cur_req = "R12";
        cyc(0, 1, 1, 0, 8'h55);
        chk(!match_valid, "R12", "stray eof before any frame", {31'd0, match_valid}, 0);

        cur_req = "R1";
        wr(3*16 + 4, 32'hDEAD_BEEF);
        rd(3*16 + 4, 32'h0000_BEEF, "R1");
        wr(3*16 + 8, 32'h1234_5678);
        rd(3*16 + 8, 32'h1234_5678, "R1");
        wr(WIN, 32'hFFFF_FFFF);
        rd(WIN, 32'h000F_7FFF, "R2");
        wr(KIND, 32'hFFFF_FFFF);
        rd(KIND, 32'h0000_FFFF, "R3");

        cur_req = "R5";
        prog_slot(0, le48(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55), 48'h0);
        rd(0, 32'h3322_1102, "R1");
        prog_slot(1, le48(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h99), le48(0, 0, 0, 0, 0, 8'hFF));
        prog_slot(2, le48(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h54), 48'h0);
        prog_slot(3, le48(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h56), 48'h0);
        prog_slot(4, 48'h0, 48'hFFFF_FFFF_FFFF);
        prog_slot(5, 48'h0, 48'hFFFF_FFFF_FFFF);
        prog_slot(6, le48(8'h03, 0, 0, 0, 0, 0), 48'h0);
        prog_slot(7, le48(8'h03, 0, 0, 0, 0, 0), 48'h0);
        wr(KIND, 32'h0000_E4E5);
        wr(WIN, 32'h0006_0000);
        cyc(0, 0, 0, 0, 0);

        set_frame(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55);
        run_frame(14);
        expect_vec(8'hAF, "R5", "frame A mixed kinds");
        chk(match_vec[6] == 0 && match_vec[7] == 1, "R6", "first byte most significant",
            {24'd0, match_vec}, 32'h80);
        chk(match_vec[4] == 0, "R7", "disabled slot silent", {24'd0, match_vec}, 0);
        cyc(0, 0, 0, 0, 0);
        cyc(0, 1, 1, 2, 8'h00);
        expect_vec(8'hAF, "R12", "stray eof after frame");

        cur_req = "R4";
        set_frame(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h99);
        run_frame(14);
        expect_vec(8'hA6, "R4", "frame B masked byte");
        cur_req = "R6";
        set_frame(8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
        run_frame(10);
        expect_vec(8'h64, "R6", "frame C all ones");

        cur_req = "R8";
        set_frame(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55);
        run_frame(4);
        expect_vec(8'h00, "R8", "short frame");
        cur_req = "R11";
        cyc(1, 0, 1, 0, 8'h02);
        chk(!match_valid && match_vec == 0, "R11", "cleared after sof", {23'd0, match_valid, match_vec}, 0);
        for (int i = 1; i < 8; i++) cyc(0, i == 7, 1, i, fr[i]);
        expect_vec(8'hAF, "R11", "result after eof");

        cur_req = "R9";
        wr(WIN, 32'h0009_0000);
        run_frame(12);
        expect_vec(8'hAF, "R9", "length 9 acts as 6");
        wr(WIN, 32'h0000_0000);
        run_frame(12);
        expect_vec(8'h23, "R9", "empty window");
        wr(WIN, 32'h0002_0006);
        set_frame(8'hFF, 8'hEE, 8'hDD, 8'hCC, 8'hBB, 8'hAA);
        fr[6] = 8'h02; fr[7] = 8'h11;
        run_frame(12);
        expect_vec(8'hA3, "R9", "window at offset six");
        run_frame(7);
        expect_vec(8'h00, "R8", "window cut by frame end");

        cur_req = "R10";
        wr(WIN, 32'h0006_0000);
        set_frame(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55);
        run_frame(1);
        run_frame(14, 3, 0, 32'h0);
        expect_vec(8'hAF, "R10", "write in flight not applied");
        run_frame(14);
        expect_vec(8'hAE, "R10", "write applied next frame");

        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R11 watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule